// File: doc/BRIEF.md
# MMU Fault Register Capture

This block records diagnostic state into the memory-management status registers when an address translation fault is raised, so that the trap handler finds the fault context already latched when it starts. A data-side fault strobe comes with the faulting virtual address, the top fields of the faulting instruction, a 6-bit access-flag field and three qualifiers: page-table-entry load, no-fault request and mis-speculated path. An instruction-side fault strobe comes with the faulting PC and its own mis-speculation qualifier.

On a qualifying data fault the block latches the address, a packed status word, and a formatted page-table address. That address is the data page-table base OR'd with the virtual page number shifted left by 3. On a qualifying instruction fault it latches the PC as a tag and a formatted address built the same way from the instruction page-table base. Every fault is forwarded to trap dispatch one cycle after its strobe, whether or not latching was suppressed. When both sides fault together, the instruction fault is forwarded first and the data fault follows on the next cycle.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset every captured register reads zero and `trap_valid` and `trap_is_insn` are low.
- R2: The data registers (`va_q`, `mmstat_q`, `vaform_q`) load only on a clock edge where `d_fault_valid` is high and `d_misspec`, `d_pte_load` and `d_no_fault` are all low; otherwise they keep their values.
- R3: On a data capture `va_q` becomes the faulting virtual address, zero-extended to 64 bits.
- R4: On a data capture `mmstat_q` bits [16:11] take the opcode (instruction bits [31:26], `d_insn_hi[10:5]`), bits [10:6] take the Ra field (instruction bits [25:21], `d_insn_hi[4:0]`), and bits [5:0] take `d_flags`.
- R5: On a data capture `vaform_q` becomes `d_ptbase` OR'd with the virtual page number (address bits [42:13], 8 KB pages) shifted left by 3.
- R6: On an instruction fault with `i_misspec` low, `itag_q` becomes the zero-extended PC and `ivaform_q` becomes `i_ptbase` OR'd with PC bits [42:13] shifted left by 3; with `i_misspec` high both hold.
- R7: Each fault strobe produces exactly one `trap_valid` pulse one cycle later, with `trap_is_insn` high for an instruction fault and low for a data fault, also when capture was suppressed; no pulse appears without a fault.
- R8: When data and instruction strobes are high in the same cycle, the instruction fault is forwarded first and the data fault on the following cycle.
- R9: Registers are captured on the same edge that raises the corresponding `trap_valid`, so the captured state is visible while the trap is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_fault_valid | input | 1 | Data translation fault strobe |
| d_va | input | 43 | Faulting data virtual address |
| d_insn_hi | input | 11 | Faulting instruction bits [31:21] |
| d_flags | input | 6 | Access-flag field |
| d_pte_load | input | 1 | Access is a page-table-entry load |
| d_no_fault | input | 1 | Access is a no-fault request |
| d_misspec | input | 1 | Data access is on a mis-speculated path |
| i_fault_valid | input | 1 | Instruction translation fault strobe |
| i_pc | input | 43 | Faulting PC |
| i_misspec | input | 1 | Instruction fetch is on a mis-speculated path |
| d_ptbase | input | 64 | Data page-table base |
| i_ptbase | input | 64 | Instruction page-table base |
| va_q | output | 64 | Captured faulting data address |
| mmstat_q | output | 17 | Captured status word |
| vaform_q | output | 64 | Captured formatted data page-table address |
| itag_q | output | 64 | Captured faulting PC |
| ivaform_q | output | 64 | Captured formatted instruction page-table address |
| trap_valid | output | 1 | Fault forwarded to trap dispatch |
| trap_is_insn | output | 1 | Forwarded fault is an instruction fault |

## Verification
The assertions assume that no new fault strobe arrives in the cycle right after a simultaneous data and instruction pair, while the deferred data fault is still waiting to be forwarded. They also assume that the page-table base inputs stay meaningful only in the strobe cycle. The stimulus drives every fault for a single cycle and follows each one with an idle cycle, so the one-deep deferral slot is always empty when a new pair arrives. The scoreboard then expects each forwarded trap together with the full register snapshot that the requirements predict.

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture #(
  parameter int VA_W       = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int REG_W      = 64,
  parameter int OPC_W      = 6,
  parameter int RA_W       = 5,
  parameter int FLAG_W     = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             d_fault_valid,
  input  logic [VA_W-1:0]                  d_va,
  input  logic [OPC_W+RA_W-1:0]            d_insn_hi,
  input  logic [FLAG_W-1:0]                d_flags,
  input  logic                             d_pte_load,
  input  logic                             d_no_fault,
  input  logic                             d_misspec,
  input  logic                             i_fault_valid,
  input  logic [VA_W-1:0]                  i_pc,
  input  logic                             i_misspec,
  input  logic [REG_W-1:0]                 d_ptbase,
  input  logic [REG_W-1:0]                 i_ptbase,
  output logic [REG_W-1:0]                 va_q,
  output logic [OPC_W+RA_W+FLAG_W-1:0]     mmstat_q,
  output logic [REG_W-1:0]                 vaform_q,
  output logic [REG_W-1:0]                 itag_q,
  output logic [REG_W-1:0]                 ivaform_q,
  output logic                             trap_valid,
  output logic                             trap_is_insn
);

  localparam int VPN_W    = VA_W - PAGE_SHIFT;
  localparam int FORM_SH  = 3;
  localparam int VA_PAD   = REG_W - VA_W;
  localparam int VPN_PAD  = REG_W - VPN_W - FORM_SH;

  logic d_cap, i_cap, d_pend;
  logic [REG_W-1:0] d_va_ext, i_pc_ext, d_vpn_form, i_vpn_form;

  assign d_cap = d_fault_valid & ~d_misspec & ~d_pte_load & ~d_no_fault;
  assign i_cap = i_fault_valid & ~i_misspec;

  assign d_va_ext   = {{VA_PAD{1'b0}}, d_va};
  assign i_pc_ext   = {{VA_PAD{1'b0}}, i_pc};
  assign d_vpn_form = {{VPN_PAD{1'b0}}, d_va[VA_W-1:PAGE_SHIFT], {FORM_SH{1'b0}}};
  assign i_vpn_form = {{VPN_PAD{1'b0}}, i_pc[VA_W-1:PAGE_SHIFT], {FORM_SH{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q     <= '0;
      mmstat_q <= '0;
      vaform_q <= '0;
    end else if (d_cap) begin
      va_q     <= d_va_ext;
      mmstat_q <= {d_insn_hi, d_flags};
      vaform_q <= d_ptbase | d_vpn_form;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      itag_q    <= '0;
      ivaform_q <= '0;
    end else if (i_cap) begin
      itag_q    <= i_pc_ext;
      ivaform_q <= i_ptbase | i_vpn_form;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid   <= 1'b0;
      trap_is_insn <= 1'b0;
      d_pend       <= 1'b0;
    end else begin
      trap_valid   <= i_fault_valid | d_fault_valid | d_pend;
      trap_is_insn <= i_fault_valid;
      d_pend       <= i_fault_valid & d_fault_valid;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !trap_valid && va_q == '0 && itag_q == '0);

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_fault_valid || d_misspec || d_pte_load || d_no_fault)
      |=> $stable(va_q) && $stable(mmstat_q) && $stable(vaform_q));

  assert_va_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    d_cap |=> va_q == $past(d_va_ext));

  assert_mmstat_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    d_cap |=> mmstat_q[FLAG_W-1:0] == $past(d_flags));

  assert_vaform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    d_cap |=> vaform_q == ($past(d_ptbase) | $past(d_vpn_form)));

  assert_insn_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!i_fault_valid || i_misspec) |=> $stable(itag_q) && $stable(ivaform_q));

  assert_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fault_valid || i_fault_valid) |=> trap_valid);

  assert_insn_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fault_valid && i_fault_valid) |=> trap_is_insn ##1 (trap_valid && !trap_is_insn));

  assert_tag_with_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    i_cap |=> trap_valid && trap_is_insn && itag_q == $past(i_pc_ext));

endmodule

// File: tb/mmu_fault_capture_bench.sv
module mmu_fault_capture_bench;

  typedef struct packed {
    logic        is_insn;
    logic [63:0] va;
    logic [16:0] ms;
    logic [63:0] vf;
    logic [63:0] it;
    logic [63:0] ivf;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic d_fault_valid = 0, d_pte_load = 0, d_no_fault = 0, d_misspec = 0;
  logic i_fault_valid = 0, i_misspec = 0;
  logic [42:0] d_va = '0, i_pc = '0;
  logic [10:0] d_insn_hi = '0;
  logic [5:0]  d_flags = '0;
  logic [63:0] d_ptbase = '0, i_ptbase = '0;
  logic [63:0] va_q, vaform_q, itag_q, ivaform_q;
  logic [16:0] mmstat_q;
  logic trap_valid, trap_is_insn;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];
  exp_t m = '0;

  always #10 clk = ~clk;

  mmu_fault_capture u_mmu_fault_capture (
    .clk, .rst_n, .d_fault_valid, .d_va, .d_insn_hi, .d_flags, .d_pte_load,
    .d_no_fault, .d_misspec, .i_fault_valid, .i_pc, .i_misspec, .d_ptbase,
    .i_ptbase, .va_q, .mmstat_q, .vaform_q, .itag_q, .ivaform_q, .trap_valid,
    .trap_is_insn);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] form(input logic [63:0] base, input logic [42:0] a);
    return base | ({34'd0, a[42:13]} << 3);
  endfunction

  task automatic fault(input bit dv, input logic [42:0] va, input logic [31:0] insn,
                       input logic [5:0] fl, input bit pte, input bit nf, input bit dms,
                       input bit iv, input logic [42:0] pc, input bit ims,
                       input logic [63:0] dbase, input logic [63:0] ibase);
    @(negedge clk);
    d_fault_valid = dv; d_va = va; d_insn_hi = insn[31:21]; d_flags = fl;
    d_pte_load = pte; d_no_fault = nf; d_misspec = dms;
    i_fault_valid = iv; i_pc = pc; i_misspec = ims;
    d_ptbase = dbase; i_ptbase = ibase;
    if (dv && !pte && !nf && !dms) begin
      m.va = {21'd0, va};
      m.ms = {insn[31:26], insn[25:21], fl};
      m.vf = form(dbase, va);
    end
    if (iv && !ims) begin
      m.it  = {21'd0, pc};
      m.ivf = form(ibase, pc);
    end
    if (iv) begin m.is_insn = 1'b1; q.push_back(m); end
    if (dv) begin m.is_insn = 1'b0; q.push_back(m); end
    @(negedge clk);
    d_fault_valid = 0; i_fault_valid = 0;
    d_pte_load = 0; d_no_fault = 0; d_misspec = 0; i_misspec = 0;
    @(negedge clk);
  endtask

  // monitor: pops one expected item per forwarded trap (R7, R8, R9)
  always @(negedge clk) begin
    if (rst_n && !done && trap_valid) begin
      if (q.size() == 0) begin
        chk("R7 spurious trap", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R7/R8 trap_is_insn", {63'd0, trap_is_insn}, {63'd0, e.is_insn});
        chk("R3 va_q", va_q, e.va);
        chk("R4 mmstat_q", {47'd0, mmstat_q}, {47'd0, e.ms});
        chk("R5 vaform_q", vaform_q, e.vf);
        chk("R6 itag_q", itag_q, e.it);
        chk("R6 ivaform_q", ivaform_q, e.ivf);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 trap_valid", {63'd0, trap_valid}, 64'd0);
    chk("R1 va_q", va_q, 64'd0);
    chk("R1 mmstat_q", {47'd0, mmstat_q}, 64'd0);
    chk("R1 itag_q", itag_q, 64'd0);
    chk("R1 ivaform_q", ivaform_q, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2/R3/R4/R5: normal data fault
    fault(1, 43'h123_4567_89AB, 32'hA7E0_0000, 6'h2B, 0, 0, 0, 0, '0, 0,
          64'hFFFF_0000_0000_0000, '0);
    // R2: page-table-entry load, no-fault request, mis-speculation hold
    fault(1, 43'h7FF_FFFF_FFFF, 32'hFFFF_FFFF, 6'h3F, 1, 0, 0, 0, '0, 0, 64'h1, '0);
    fault(1, 43'h555_5555_5555, 32'h1234_5678, 6'h11, 0, 1, 0, 0, '0, 0, 64'h2, '0);
    fault(1, 43'h2AA_AAAA_AAAA, 32'h8765_4321, 6'h22, 0, 0, 1, 0, '0, 0, 64'h3, '0);
    // R5 boundary: all-ones address, page offset bits do not reach the form
    fault(1, 43'h7FF_FFFF_FFFF, 32'hFC00_0000, 6'h00, 0, 0, 0, 0, '0, 0, '0, '0);
    fault(1, 43'h000_0000_1FFF, 32'h03E0_0000, 6'h01, 0, 0, 0, 0, '0, 0, 64'h8000_0000_0000_0000, '0);
    // R6: instruction fault and mis-speculated instruction fault
    fault(0, '0, '0, '0, 0, 0, 0, 1, 43'h0AB_CDEF_0123, 0, '0, 64'hC000_0000_0000_0007);
    fault(0, '0, '0, '0, 0, 0, 0, 1, 43'h7FF_FFFF_FFFF, 1, '0, 64'h1);
    // R8: simultaneous faults, then with data suppressed
    fault(1, 43'h111_2222_3333, 32'h4C40_0000, 6'h15, 0, 0, 0, 1, 43'h444_5555_6666, 0,
          64'h10, 64'h20);
    fault(1, 43'h777_0000_0000, 32'hFFFF_FFFF, 6'h3F, 1, 0, 0, 1, 43'h000_0000_2000, 0,
          '0, '0);
    // R9: back-to-back single faults
    fault(0, '0, '0, '0, 0, 0, 0, 1, 43'h3FF_FFFF_E000, 0, '0, '0);
    fault(1, 43'h000_0000_2000, 32'h0000_0000, 6'h3F, 0, 0, 0, 0, '0, 0, '0, '0);
    repeat (4) @(negedge clk);
    chk("R7 all traps forwarded", q.size(), 64'd0);
    chk("R7 quiet when idle", {63'd0, trap_valid}, 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule